// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Set and Clear Registers

This block gathers five interrupt sources into sticky status bits. It gates those bits with an enable mask that software writes, and it reduces the result to one registered interrupt line. The five sources are the controller core interrupt, a hot-plug rising event, a hot-plug falling event, a nonce-refresh rising event and a random-number error. The core interrupt arrives as a level and is captured on its rising edge. The other four arrive as event pulses and are captured in every cycle they are high. A `SRC_EDGE` parameter chooses edge or level capture for each source.

Software works through a small word-wide register port with three locations. The enable location holds the mask. Writing 1s to the status location forces status bits set, and reading it returns the status together with the live core interrupt level in the top bit. Writing 1s to the clear location acknowledges status bits. A hardware event that lands in the same cycle as a clear of its bit wins, so no event is lost. The read port is combinational and the write port takes effect at the clock edge. An asynchronous active-low reset is applied at once and released in step with the clock.

Top module: `irq_aggregator`

## Requirements
- R1: While reset is applied and after it is released, the enable mask and all status bits are 0 and `irq_o` is 0.
- R2: Writing address 0 loads the mask from `wr_data_i[4:0]`, where bit 0 is core, bit 1 is hot-plug rise, bit 2 is hot-plug fall, bit 3 is nonce refresh and bit 4 is random-number error. Reading address 0 returns the mask in bits 4:0, and all other bits read 0.
- R3: A status bit that is set stays set until a clear write hits it, whatever the source does afterwards.
- R4: Status bit 0 sets in the cycle after `src_i[0]` goes from 0 to 1. A level that stays high does not set the bit again after it has been cleared.
- R5: Status bits 1 to 4 set at every clock edge where their source input is high.
- R6: Writing address 1 sets each status bit whose data bit is 1. Data bits that are 0 leave the status unchanged.
- R7: Writing address 2 clears each status bit whose data bit is 1. Data bits that are 0 leave the status unchanged, and reading address 2 returns 0.
- R8: When a capture and a clear fall on the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` equals the OR of (status AND mask) as it stood one clock earlier.
- R10: Reading address 1 returns the status in bits 4:0 and the live `src_i[0]` level in bit DATA_W-1, with all other bits 0.
- R11: Writes to any address above 2 change neither the mask nor the status, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 5 | Interrupt sources, bit order as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit data word, a 3-bit address and edge capture on the core source only. Under these settings the live level sits at bit 31, far from the five status bits, so a misplaced live bit shows up in the read data. The 3-bit address leaves five unmapped locations, and writes and reads there exercise the decode. Because only the core source is edge-captured, one run covers a held-high core level against held-high pulse sources, which must keep setting their bits.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned NUM_SRC = 5;

  // source bit positions
  localparam int unsigned SRC_CORE  = 0;
  localparam int unsigned SRC_HPR   = 1;
  localparam int unsigned SRC_HPF   = 2;
  localparam int unsigned SRC_NONCE = 3;
  localparam int unsigned SRC_RNG   = 4;

  // register word offsets
  localparam int unsigned OFS_MASK = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_CLR  = 2;

  typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_edge_capture.sv
module irq_edge_capture
  import irq_agg_pkg::*;
#(
  parameter src_vec_t EDGE_SEL = src_vec_t'(1)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t src_i,
  output src_vec_t evt_o
);
  src_vec_t prev_q;
  src_vec_t prev_d;

  always_comb begin
    prev_d = src_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (EDGE_SEL[g]) begin : g_edge
      assign evt_o[g] = src_i[g] & ~prev_q[g];
    end else begin : g_level
      logic unused_prev;
      assign unused_prev = prev_q[g];
      assign evt_o[g] = src_i[g];
    end
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  src_vec_t          status_i,
  input  logic              live_i,
  output src_vec_t          mask_o,
  output src_vec_t          set_o,
  output src_vec_t          clr_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLR);
  localparam int unsigned       LIVE_BIT = DATA_W - 1;

  logic     hit_mask, hit_stat, hit_clr;
  logic     mask_en;
  src_vec_t mask_q, mask_d;
  src_vec_t wr_bits;
  logic     unused_wr_hi;

  assign wr_bits      = wr_data_i[NUM_SRC-1:0];
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:NUM_SRC];

  always_comb begin
    hit_mask = wr_en_i && (wr_addr_i == A_MASK);
    hit_stat = wr_en_i && (wr_addr_i == A_STAT);
    hit_clr  = wr_en_i && (wr_addr_i == A_CLR);
  end

  // mask register: next state and enable
  always_comb begin
    mask_en = hit_mask;
    mask_d  = wr_bits;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  // set and clear strobes, one cycle wide, only bits written as 1
  always_comb begin
    set_o = hit_stat ? wr_bits : '0;
    clr_o = hit_clr  ? wr_bits : '0;
  end

  // read mux
  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      A_MASK: rd_data_o[NUM_SRC-1:0] = mask_q;
      A_STAT: begin
        rd_data_o[NUM_SRC-1:0] = status_i;
        rd_data_o[LIVE_BIT]    = live_i;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_agg_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  src_vec_t evt_i,
  input  src_vec_t set_i,
  input  src_vec_t clr_i,
  input  src_vec_t mask_i,
  output src_vec_t status_o,
  output logic     irq_o
);
  src_vec_t status_q, status_d;
  logic     status_en;
  logic     irq_q, irq_d;

  // captures and software sets take priority over a clear
  always_comb begin
    status_en = |{evt_i, set_i, clr_i};
    status_d  = (status_q & ~clr_i) | evt_i | set_i;
    irq_d     = |(status_q & mask_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign status_o = status_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 3,
  parameter src_vec_t    SRC_EDGE = src_vec_t'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        src_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic     rst_n_int;
  src_vec_t evt;
  src_vec_t set_vec;
  src_vec_t clr_vec;
  src_vec_t mask_q;
  src_vec_t status_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  irq_edge_capture #(.EDGE_SEL(SRC_EDGE)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .src_i  (src_i),
    .evt_o  (evt)
  );

  irq_reg_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .status_i  (status_q),
    .live_i    (src_i[SRC_CORE]),
    .mask_o    (mask_q),
    .set_o     (set_vec),
    .clr_o     (clr_vec),
    .rd_data_o (rd_data_o)
  );

  irq_status_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .evt_i    (evt),
    .set_i    (set_vec),
    .clr_i    (clr_vec),
    .mask_i   (mask_q),
    .status_o (status_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic [4:0]        src_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_o,
  input src_vec_t          evt,
  input src_vec_t          set_vec,
  input src_vec_t          clr_vec,
  input src_vec_t          mask_q,
  input src_vec_t          status_q
);
  // R3: without a clear, no status bit drops
  a_r3_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_vec == '0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: a captured event is set after the edge even against a clear
  a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    (evt != '0) |=> ((status_q & $past(evt)) == $past(evt)));

  // R7: cleared bits without a same-cycle event read 0 afterwards
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((clr_vec & ~evt) != '0) |=> ((status_q & $past(clr_vec & ~evt)) == '0));

  // R6: a status bit only rises through a capture or a software set
  a_r6_no_stray_set: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt | set_vec)) == '0));

  // R9: output is the masked status one cycle late
  a_r9_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_n)
    1'b1 |=> (irq_o == (|($past(status_q & mask_q)))));

  // R2: mask holds unless its location is written
  a_r2_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i && (wr_addr_i == ADDR_W'(OFS_MASK))) |=> $stable(mask_q));

  // R10: status read carries the live core level in the top bit
  a_r10_live_bit: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == ADDR_W'(OFS_STAT)) |-> (rd_data_o[DATA_W-1] == src_i[SRC_CORE]));
endmodule

bind irq_aggregator irq_aggregator_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_n     (rst_n_int),
  .src_i     (src_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .evt       (evt),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .mask_q    (mask_q),
  .status_q  (status_q)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam int DW = 32;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic [4:0]    src;
  logic          we;
  logic [AW-1:0] wa;
  logic [DW-1:0] wd;
  logic [AW-1:0] ra;
  logic [DW-1:0] rd;
  logic          irq;

  int nvec = 0;
  int nfail = 0;
  bit done = 0;

  // reference state
  logic [4:0] m_mask = '0;
  logic [4:0] m_stat = '0;
  logic       m_prev = 1'b0;
  logic       m_irq  = 1'b0;

  always #2 clk = ~clk;

  irq_aggregator #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
  );

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic live);
    logic [DW-1:0] r = '0;
    if (a == 0) r[4:0] = m_mask;
    else if (a == 1) begin r[4:0] = m_stat; r[DW-1] = live; end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    logic [4:0] ev, st, cl;
    ev = {src[4:1], src[0] & ~m_prev};
    m_prev = src[0];
    m_irq = |(m_stat & m_mask);
    st = (we && wa == 1) ? wd[4:0] : 5'b0;
    cl = (we && wa == 2) ? wd[4:0] : 5'b0;
    if (we && wa == 0) m_mask = wd[4:0];
    m_stat = (m_stat & ~cl) | ev | st;
  endtask

  // called at a falling edge: drive, clock, check at next falling edge
  task automatic cyc(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input logic [4:0] s, input logic [AW-1:0] r, input string tag);
    we = w; wa = a; wd = d; src = s; ra = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, rd, exp_read(r, s[0]));
    chk({tag, "/R9"}, {31'b0, irq}, {31'b0, m_irq});
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A5C_0DE5));
    rst_ni = 1'b0; we = 0; wa = 0; wd = 0; src = 0; ra = 0;
    repeat (3) @(negedge clk);
    // R1: state while reset is applied
    ra = 0; #0; chk("R1", rd, 32'h0);
    ra = 1; #1; chk("R1", rd, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) cyc(0, 0, 0, 0, 1, "R1");

    // R2 mask load, upper data bits ignored
    cyc(1, 0, 32'hFFFF_FFEA, 0, 0, "R2");
    // R6 software set and zero write
    cyc(1, 1, 32'hFFFF_FFE1, 0, 1, "R6");
    cyc(1, 1, 32'h0, 0, 1, "R6");
    // R9 masked-off bit 0 gives no irq; bit 1 enabled
    cyc(0, 0, 0, 0, 1, "R9");
    cyc(1, 1, 32'h2, 0, 1, "R9");
    cyc(0, 0, 0, 0, 1, "R9");
    // R7 clear, zero clear, clear location reads 0
    cyc(1, 2, 32'hFFFF_FFE1, 0, 1, "R7");
    cyc(1, 2, 32'h0, 0, 1, "R7");
    cyc(0, 0, 0, 0, 2, "R7");
    cyc(1, 2, 32'h1F, 0, 1, "R7");
    // R4 core edge capture, held level not recaptured after clear
    cyc(0, 0, 0, 5'h01, 1, "R4");
    cyc(0, 0, 0, 5'h01, 1, "R4");
    cyc(1, 2, 32'h1, 5'h01, 1, "R4");
    cyc(0, 0, 0, 5'h01, 1, "R4");
    cyc(0, 0, 0, 5'h00, 1, "R10");
    cyc(0, 0, 0, 5'h01, 1, "R4");
    // R5 pulse sources, R3 stickiness afterwards
    cyc(1, 2, 32'h1F, 5'h04, 1, "R5");
    cyc(0, 0, 0, 5'h10, 1, "R5");
    cyc(0, 0, 0, 5'h00, 1, "R3");
    cyc(0, 0, 0, 5'h00, 1, "R3");
    // R8 event and clear in the same cycle
    cyc(1, 2, 32'h1F, 5'h08, 1, "R8");
    cyc(1, 2, 32'h1F, 5'h01, 1, "R8");
    cyc(0, 0, 0, 5'h01, 1, "R10");
    // R11 unmapped addresses
    cyc(1, 5, 32'hFFFF_FFFF, 5'h00, 0, "R11");
    cyc(1, 3, 32'hFFFF_FFFF, 5'h00, 1, "R11");
    cyc(0, 0, 0, 5'h00, 5, "R11");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      logic [4:0] s;
      logic [AW-1:0] a, r;
      logic w;
      s = {(($urandom % 6) == 0) ? 4'($urandom) : 4'b0,
           (($urandom % 5) == 0) ? ~src[0] : src[0]};
      w = (($urandom % 3) == 0);
      a = AW'($urandom % 4);
      if (a == 3) a = AW'(5 + ($urandom % 3));
      r = AW'($urandom % 3);
      cyc(w, a, $urandom, s, r, "R3");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule